// File: doc/BRIEF.md
# Sleep and Fault-Reset Pulse Decoder

This block watches an asynchronous active-low sleep request pin and decides what each low excursion on it means. A low pulse whose width falls inside a reset window clears the latched faults elsewhere in the chip by issuing a one-cycle clear strobe. A low level held long enough puts the block, and the power stage it gates, to sleep. Low pulses that are too short, or that fall in the gap between the reset window and the sleep threshold, are dropped. The pin passes through a two-flop synchronizer before any width is measured.

When the pin returns high from sleep, a wake timer starts. The outputs-ready flag and the fault-release control (held low until release) rise together only once the pin has stayed high for the full wake time. A low excursion during the wake period restarts that timer. Every threshold is given in nanoseconds and turned into clock cycles from a clock-frequency parameter, so the same block serves any clock. While asleep or waking, the outputs-ready flag stays low, which the surrounding logic uses to keep the bridge drivers off and ignore their command inputs.

Top module: `sleep_pulse_decoder`

## Requirements
- R1: During and straight after reset, `asleep` is 1, `out_ready` is 0, `fault_hold_n` is 0 and `flt_clr` is 0.
- R2: While awake, a low pulse of the synchronized pin lasting from RST_MIN_CYC to RST_MAX_CYC cycles inclusive gives exactly one `flt_clr` pulse of one cycle, issued after the pin returns high; the state and `out_ready` stay unchanged.
- R3: While awake, a low pulse shorter than RST_MIN_CYC cycles gives no `flt_clr` and changes no output.
- R4: While awake, a low pulse from RST_MAX_CYC+1 to SLEEP_CYC-1 cycles gives no `flt_clr`, no sleep entry and leaves `out_ready` at 1.
- R5: A low level lasting SLEEP_CYC cycles sets `asleep` to 1 and drives `out_ready` and `fault_hold_n` to 0; whenever `asleep` is 1, `out_ready` and `fault_hold_n` are 0.
- R6: After the pin returns high from sleep (or after reset), `asleep` falls and `out_ready` and `fault_hold_n` rise only after the synchronized pin has been high for at least WAKE_CYC consecutive cycles.
- R7: A low pulse while waking restarts the wake timer, so readiness then comes WAKE_CYC high cycles after that pulse ends.
- R8: The rising edge of the pin that ends a sleep never produces `flt_clr`, whatever the length of the low period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the caller |
| sleep_n_pin | input | 1 | Asynchronous active-low sleep/fault-reset request pin |
| flt_clr | output | 1 | One-cycle fault-clear strobe |
| asleep | output | 1 | 1 while in the sleep state |
| out_ready | output | 1 | 1 once the wake time has completed and the block is awake |
| fault_hold_n | output | 1 | Active-low fault-release control: 0 holds the fault indicator, 1 releases it |

## Verification
Every cycle, the assertions check that sleep forces the ready flag and release control low, that the clear strobe is a single cycle following a rising edge of the synchronized pin while awake, and, against counters kept in the checker, that sleep is entered only after SLEEP_CYC low cycles and readiness only after WAKE_CYC high cycles. Only the bench scenarios show the classification itself: that widths on each side of both reset-window edges and of the sleep threshold take the right action, that pulses in the dead gap are dropped, and that a pulse during waking postpones readiness by a whole new wake period.

// File: rtl/sleep_pulse_pkg.sv
package sleep_pulse_pkg;
  typedef enum logic [1:0] {
    PH_SLEEP = 2'd0,
    PH_WAKE  = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;
endpackage

// File: rtl/spd_sync.sv
module spd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spd_low_meter.sv
module spd_low_meter #(
  parameter int MIN_CYC   = 20,
  parameter int MAX_CYC   = 40,
  parameter int SLEEP_CYC = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic in_clr_win,
  output logic sleep_hit
);
  localparam int CW = $clog2(SLEEP_CYC + 1);
  localparam logic [CW-1:0] MIN_V   = CW'(MIN_CYC);
  localparam logic [CW-1:0] MAX_V   = CW'(MAX_CYC);
  localparam logic [CW-1:0] SAT_V   = CW'(SLEEP_CYC);
  localparam logic [CW-1:0] TRIP_V  = CW'(SLEEP_CYC - 1);

  logic [CW-1:0] lo_cnt_q, lo_cnt_d;
  logic          prev_q;

  always_comb begin
    if (lvl)                lo_cnt_d = '0;
    else if (lo_cnt_q == SAT_V) lo_cnt_d = lo_cnt_q;
    else                    lo_cnt_d = lo_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt_q <= '0;
      prev_q   <= 1'b0;
    end else begin
      lo_cnt_q <= lo_cnt_d;
      prev_q   <= lvl;
    end
  end

  assign rise       = lvl & ~prev_q;
  assign in_clr_win = (lo_cnt_q >= MIN_V) && (lo_cnt_q <= MAX_V);
  assign sleep_hit  = ~lvl && (lo_cnt_q == TRIP_V);
endmodule

// File: rtl/spd_wake_timer.sv
module spd_wake_timer #(
  parameter int WAKE_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int TW = $clog2(WAKE_CYC + 1);
  localparam logic [TW-1:0] LAST_V = TW'(WAKE_CYC - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = run && (cnt_q != LAST_V);

  always_comb begin
    if (!run)        cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = run && (cnt_q == LAST_V);
endmodule

// File: rtl/sleep_pulse_decoder.sv
module sleep_pulse_decoder #(
  parameter int CLK_MHZ     = 250,
  parameter int RST_MIN_NS  = 20000,
  parameter int RST_MAX_NS  = 40000,
  parameter int SLEEP_NS    = 120000,
  parameter int WAKE_NS     = 1000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_n_pin,
  output logic flt_clr,
  output logic asleep,
  output logic out_ready,
  output logic fault_hold_n
);
  import sleep_pulse_pkg::*;

  localparam int RST_MIN_CYC = CLK_MHZ * RST_MIN_NS / 1000;
  localparam int RST_MAX_CYC = CLK_MHZ * RST_MAX_NS / 1000;
  localparam int SLEEP_CYC   = CLK_MHZ * SLEEP_NS / 1000;
  localparam int WAKE_CYC    = CLK_MHZ * WAKE_NS / 1000;

  logic   sync_lvl;
  logic   rise, in_clr_win, sleep_hit;
  logic   wake_run, wake_done;
  phase_t phase_q, phase_d;
  logic   clr_d;

  spd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sleep_n_pin), .q(sync_lvl)
  );

  spd_low_meter #(
    .MIN_CYC(RST_MIN_CYC), .MAX_CYC(RST_MAX_CYC), .SLEEP_CYC(SLEEP_CYC)
  ) u_meter (
    .clk(clk), .rst_n(rst_n), .lvl(sync_lvl),
    .rise(rise), .in_clr_win(in_clr_win), .sleep_hit(sleep_hit)
  );

  assign wake_run = (phase_q == PH_WAKE) && sync_lvl;

  spd_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk(clk), .rst_n(rst_n), .run(wake_run), .done(wake_done)
  );

  // next-state process
  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_SLEEP: if (sync_lvl)       phase_d = PH_WAKE;
      PH_WAKE: begin
        if (sleep_hit)              phase_d = PH_SLEEP;
        else if (wake_done)         phase_d = PH_RUN;
      end
      PH_RUN:   if (sleep_hit)      phase_d = PH_SLEEP;
      default:                      phase_d = PH_SLEEP;
    endcase
  end

  assign clr_d = rise && in_clr_win && (phase_q != PH_SLEEP);

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q      <= PH_SLEEP;
      flt_clr      <= 1'b0;
      asleep       <= 1'b1;
      out_ready    <= 1'b0;
      fault_hold_n <= 1'b0;
    end else begin
      phase_q      <= phase_d;
      flt_clr      <= clr_d;
      asleep       <= (phase_d == PH_SLEEP);
      out_ready    <= (phase_d == PH_RUN);
      fault_hold_n <= (phase_d == PH_RUN);
    end
  end
endmodule

// File: rtl/sleep_pulse_checker.sv
module sleep_pulse_checker #(
  parameter int SLEEP_CYC = 120,
  parameter int WAKE_CYC  = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic lvl,
  input logic flt_clr,
  input logic asleep,
  input logic out_ready,
  input logic fault_hold_n
);
  localparam int LW = $clog2(SLEEP_CYC + 1);
  localparam int HW = $clog2(WAKE_CYC + 1);
  localparam logic [LW-1:0] LSAT = LW'(SLEEP_CYC);
  localparam logic [HW-1:0] HSAT = HW'(WAKE_CYC);

  logic [LW-1:0] lo_run_q;
  logic [HW-1:0] hi_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run_q <= '0;
      hi_run_q <= '0;
    end else begin
      lo_run_q <= lvl ? '0 : ((lo_run_q == LSAT) ? lo_run_q : lo_run_q + 1'b1);
      hi_run_q <= !lvl ? '0 : ((hi_run_q == HSAT) ? hi_run_q : hi_run_q + 1'b1);
    end
  end

  assert_sleep_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (!out_ready && !fault_hold_n));

  assert_sleep_after_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> (lo_run_q >= LSAT));

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flt_clr |=> !flt_clr);

  assert_strobe_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flt_clr |-> ($past(lvl) && !$past(lvl, 2)));

  assert_no_strobe_asleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flt_clr |-> !$past(asleep));

  assert_ready_after_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_ready) |-> (hi_run_q >= HSAT));

  assert_release_after_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_hold_n) |-> (hi_run_q >= HSAT));
endmodule

bind sleep_pulse_decoder sleep_pulse_checker #(
  .SLEEP_CYC(SLEEP_CYC), .WAKE_CYC(WAKE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lvl(sync_lvl), .flt_clr(flt_clr),
  .asleep(asleep), .out_ready(out_ready), .fault_hold_n(fault_hold_n)
);

// File: tb/test_sleep_pulse_decoder.sv
`timescale 1ns/1ps
module test_sleep_pulse_decoder;
  localparam int MHZ    = 250;
  localparam int MIN_NS = 80;
  localparam int MAX_NS = 160;
  localparam int SLP_NS = 480;
  localparam int WK_NS  = 4000;
  localparam int MIN_C  = MHZ * MIN_NS / 1000;  // 20
  localparam int MAX_C  = MHZ * MAX_NS / 1000;  // 40
  localparam int SLP_C  = MHZ * SLP_NS / 1000;  // 120
  localparam int WK_C   = MHZ * WK_NS / 1000;   // 1000

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b1;
  logic flt_clr, asleep, out_ready, fault_hold_n;

  int total = 0;
  int bad = 0;
  int clr_seen = 0;
  bit slept_seen = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sleep_pulse_decoder #(
    .CLK_MHZ(MHZ), .RST_MIN_NS(MIN_NS), .RST_MAX_NS(MAX_NS),
    .SLEEP_NS(SLP_NS), .WAKE_NS(WK_NS)
  ) i_sleep_pulse_decoder (
    .clk(clk), .rst_n(rst_n), .sleep_n_pin(pin), .flt_clr(flt_clr),
    .asleep(asleep), .out_ready(out_ready), .fault_hold_n(fault_hold_n)
  );

  always @(negedge clk) begin
    if (flt_clr) clr_seen++;
    if (asleep)  slept_seen = 1'b1;
  end

  function automatic int expect_kind(input int w);
    if (w >= SLP_C) return 2;
    if (w >= MIN_C && w <= MAX_C) return 1;
    return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic low_pulse(input int w);
    @(negedge clk);
    pin = 1'b0;
    wait_cyc(w);
    pin = 1'b1;
  endtask

  // one pulse from the running state, checked against the classifier
  task automatic run_pulse(input int w, input string req);
    int kind;
    kind = expect_kind(w);
    clr_seen = 0;
    slept_seen = 1'b0;
    low_pulse(w);
    wait_cyc(5);
    check({req, " strobes"}, clr_seen, (kind == 1) ? 1 : 0);
    check({req, " sleep"}, int'(slept_seen), (kind == 2) ? 1 : 0);
    check({req, " ready"}, int'(out_ready), (kind == 2) ? 0 : 1);
    if (kind == 2) begin
      wait_cyc(WK_C + 4);
      check("R6 ready after wake", int'(out_ready), 1);
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 asleep", int'(asleep), 1);
    check("R1 out_ready", int'(out_ready), 0);
    check("R1 fault_hold_n", int'(fault_hold_n), 0);
    check("R1 flt_clr", int'(flt_clr), 0);
    // R6 wake after reset: not early, then ready
    wait_cyc(WK_C - 2);
    check("R6 early ready", int'(out_ready), 0);
    wait_cyc(6);
    check("R6 ready", int'(out_ready), 1);
    check("R6 release", int'(fault_hold_n), 1);
    check("R6 awake", int'(asleep), 0);

    // directed edges
    run_pulse(MIN_C - 1, "R3 below min");
    run_pulse(MIN_C,     "R2 at min");
    run_pulse(MAX_C,     "R2 at max");
    run_pulse(MAX_C + 1, "R4 above max");
    run_pulse(SLP_C - 1, "R4 below sleep");
    run_pulse(1,         "R3 one cycle");

    // R5 / R8: long sleep then release
    clr_seen = 0;
    @(negedge clk);
    pin = 1'b0;
    wait_cyc(SLP_C + 4);
    check("R5 asleep", int'(asleep), 1);
    check("R5 ready low", int'(out_ready), 0);
    check("R5 hold low", int'(fault_hold_n), 0);
    wait_cyc(200);
    pin = 1'b1;
    wait_cyc(WK_C);
    check("R6 not ready at wake time", int'(out_ready), 0);
    wait_cyc(4);
    check("R6 ready", int'(out_ready), 1);
    check("R8 no strobe on wake", clr_seen, 0);

    // R7: glitch while waking restarts the timer
    @(negedge clk);
    pin = 1'b0;
    wait_cyc(SLP_C + 2);
    pin = 1'b1;
    wait_cyc(WK_C / 2);
    low_pulse(5);
    wait_cyc(WK_C - 3);
    check("R7 restart not ready", int'(out_ready), 0);
    check("R7 still awake", int'(asleep), 0);
    wait_cyc(8);
    check("R7 ready later", int'(out_ready), 1);

    // random widths
    for (int n = 0; n < 40; n++) begin
      int w;
      w = 1 + int'($urandom % 160);
      run_pulse(w, "R2/R3/R4/R5 random");
      wait_cyc(3 + int'($urandom % 8));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_cyc(150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule